// File: doc/BRIEF.md
# Tiered Write-Once Protection Register Bank

This block holds the protection settings of a multi-channel PWM timer: a dead-time value, the idle output levels, the controls of two break inputs, the automatic output enable, the off-state selects, and the per-channel output polarity and output-compare mode. Software writes these settings over a simple register bus with full-word writes, and the timer logic reads them from the output ports.

A two-bit lock level guards the settings against runaway software. The first write to the main word after reset fixes the lock level, and that value cannot change again until the next reset. Each higher level freezes a larger group of fields, and each level includes everything frozen by the levels below it. The polarity and mode fields of a channel are frozen only while the timer marks that channel as an output.

Top module: `prot_lock_regs`

## Requirements
- R1: The first write to address 0 after reset commits bits [9:8] of the write data as the lock level, including a value of 0. Writes to other addresses do not commit it. The lock level is visible on `lock_level` and on `main_cfg[9:8]`.
- R2: Once the lock level is committed, later writes to address 0 leave the lock level unchanged until reset.
- R3: At lock level 0 every stored field takes the written value. Main-word bits 15, 22 and 23 always read 0. Address 1 holds the idle levels at bits {2c+1,2c}, address 2 holds the polarities at bits {2c+1,2c}, and address 3 holds the mode in bits [4c+2:4c] and the preload flag in bit 4c+3 for channel c.
- R4: At lock level 1 and above, the dead time (main bits [7:0]) is frozen. So are all break fields (bits 12, 13, [19:16], 20, 21, [27:24], 28 to 31), the auto-enable bit (bit 14) and all idle levels (address 1).
- R5: At lock level 2 and above, the off-state selects (main bits 10 and 11) are also frozen, and so are the polarity bits of every channel whose `ch_is_out` bit is 1 at the time of the write.
- R6: At lock level 3, the mode and preload bits of every channel whose `ch_is_out` bit is 1 at the time of the write are also frozen.
- R7: A channel whose `ch_is_out` bit is 0 accepts writes to its polarity and mode bits at every lock level.
- R8: In a write that touches both frozen and open fields, the frozen fields keep their values and the open fields update in the next cycle.
- R9: Synchronous reset clears every field and returns the lock level to 0 in an uncommitted state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | AW | Word address, 0 to 3 |
| bus_wdata | input | 32 | Write data |
| ch_is_out | input | NCH | Per-channel flag: channel is configured as an output |
| main_cfg | output | 32 | Main protection word, lock level at bits [9:8] |
| idle_lvl | output | 2*NCH | Idle levels, main and complementary, per channel |
| out_pol | output | 2*NCH | Output polarities, main and complementary, per channel |
| out_mode | output | NCH*(MODE_W+1) | Per-channel mode and preload |
| lock_level | output | 2 | Committed lock level |

## Verification
The assertions assume that every bus input and `ch_is_out` is stable around the rising edge. They also assume that reset is held for at least one full cycle, so that a frozen field is judged only against its value in the previous cycle. The stimulus changes every input on the falling edge and holds each write for exactly one cycle. It draws the address from the four decoded words, and picks a new random `ch_is_out` pattern with each write so that frozen and open channels are mixed at every lock level.

// File: rtl/prot_lock_pkg.sv
package prot_lock_pkg;
    localparam int DW = 32;

    typedef enum logic [1:0] {
        LVL_OPEN  = 2'd0,
        LVL_BASIC = 2'd1,
        LVL_POL   = 2'd2,
        LVL_FULL  = 2'd3
    } lock_lvl_e;

    localparam int A_MAIN = 0;
    localparam int A_IDLE = 1;
    localparam int A_POL  = 2;
    localparam int A_MODE = 3;

    localparam int LOCK_LSB = 8;

    // stored main-word bits: lock and reserved bits excluded
    localparam logic [DW-1:0] MAIN_STORE = 32'hFF3F_7CFF;
    // off-state select bits, still writable at the basic level
    localparam logic [DW-1:0] MAIN_OFFSEL = 32'h0000_0C00;

    function automatic logic [DW-1:0] main_wmask(input lock_lvl_e lvl);
        case (lvl)
            LVL_OPEN:  main_wmask = MAIN_STORE;
            LVL_BASIC: main_wmask = MAIN_OFFSEL;
            default:   main_wmask = '0;
        endcase
    endfunction

    function automatic logic lvl_at_least(input lock_lvl_e lvl, input lock_lvl_e ref_lvl);
        lvl_at_least = (lvl >= ref_lvl);
    endfunction
endpackage

// File: rtl/prot_lock_ctrl.sv
module prot_lock_ctrl
    import prot_lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       commit_we,
    input  logic [1:0] commit_val,
    output lock_lvl_e  lvl,
    output logic       done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl  <= LVL_OPEN;
            done <= 1'b0;
        end else if (commit_we && !done) begin
            lvl  <= lock_lvl_e'(commit_val);
            done <= 1'b1;
        end
    end
endmodule

// File: rtl/prot_main_word.sv
module prot_main_word
    import prot_lock_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  lock_lvl_e     lvl,
    output logic [DW-1:0] q
);
    logic [DW-1:0] mask;

    always_comb mask = main_wmask(lvl);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= (q & ~mask) | (wdata & mask);
    end
endmodule

// File: rtl/prot_chan_slot.sv
module prot_chan_slot
    import prot_lock_pkg::*;
#(
    parameter int MODE_W = 3,
    localparam int SLOT_W = MODE_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  lock_lvl_e         lvl,
    input  logic              is_out,
    input  logic              we_idle,
    input  logic              we_pol,
    input  logic              we_mode,
    input  logic [1:0]        w_pair,
    input  logic [SLOT_W-1:0] w_slot,
    output logic [1:0]        idle_q,
    output logic [1:0]        pol_q,
    output logic [SLOT_W-1:0] mode_q
);
    logic idle_open, pol_open, mode_open;

    always_comb begin
        idle_open = !lvl_at_least(lvl, LVL_BASIC);
        pol_open  = !(is_out && lvl_at_least(lvl, LVL_POL));
        mode_open = !(is_out && lvl_at_least(lvl, LVL_FULL));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= '0;
            pol_q  <= '0;
            mode_q <= '0;
        end else begin
            if (we_idle && idle_open) idle_q <= w_pair;
            if (we_pol && pol_open)   pol_q  <= w_pair;
            if (we_mode && mode_open) mode_q <= w_slot;
        end
    end
endmodule

// File: rtl/prot_lock_regs.sv
module prot_lock_regs
    import prot_lock_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int MODE_W = 3,
    parameter int AW     = 2,
    localparam int SLOT_W = MODE_W + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_we,
    input  logic [AW-1:0]         bus_addr,
    input  logic [31:0]           bus_wdata,
    input  logic [NCH-1:0]        ch_is_out,
    output logic [31:0]           main_cfg,
    output logic [2*NCH-1:0]      idle_lvl,
    output logic [2*NCH-1:0]      out_pol,
    output logic [NCH*SLOT_W-1:0] out_mode,
    output logic [1:0]            lock_level
);
    lock_lvl_e     lvl;
    logic          lock_done;
    logic          we_main, we_idle, we_pol, we_mode;
    logic [DW-1:0] main_q;

    always_comb begin
        we_main = bus_we && (bus_addr == AW'(A_MAIN));
        we_idle = bus_we && (bus_addr == AW'(A_IDLE));
        we_pol  = bus_we && (bus_addr == AW'(A_POL));
        we_mode = bus_we && (bus_addr == AW'(A_MODE));
    end

    prot_lock_ctrl u_lock (
        .clk        (clk),
        .rst        (rst),
        .commit_we  (we_main),
        .commit_val (bus_wdata[LOCK_LSB+1:LOCK_LSB]),
        .lvl        (lvl),
        .done       (lock_done)
    );

    prot_main_word u_main (
        .clk   (clk),
        .rst   (rst),
        .we    (we_main),
        .wdata (bus_wdata),
        .lvl   (lvl),
        .q     (main_q)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        prot_chan_slot #(.MODE_W(MODE_W)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .lvl     (lvl),
            .is_out  (ch_is_out[c]),
            .we_idle (we_idle),
            .we_pol  (we_pol),
            .we_mode (we_mode),
            .w_pair  (bus_wdata[2*c +: 2]),
            .w_slot  (bus_wdata[SLOT_W*c +: SLOT_W]),
            .idle_q  (idle_lvl[2*c +: 2]),
            .pol_q   (out_pol[2*c +: 2]),
            .mode_q  (out_mode[SLOT_W*c +: SLOT_W])
        );
    end

    always_comb begin
        lock_level = lvl;
        main_cfg   = main_q;
        main_cfg[LOCK_LSB+1:LOCK_LSB] = lvl;
    end
endmodule

// File: rtl/prot_lock_chk.sv
module prot_lock_chk #(
    parameter int NCH    = 4,
    parameter int MODE_W = 3,
    parameter int AW     = 2,
    localparam int SLOT_W = MODE_W + 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_we,
    input logic [AW-1:0]         bus_addr,
    input logic [31:0]           bus_wdata,
    input logic [NCH-1:0]        ch_is_out,
    input logic [31:0]           main_cfg,
    input logic [2*NCH-1:0]      idle_lvl,
    input logic [2*NCH-1:0]      out_pol,
    input logic [NCH*SLOT_W-1:0] out_mode,
    input logic [1:0]            lock_level,
    input logic                  lock_done
);
    assert_lock_commit_R1: assert property (@(posedge clk) disable iff (rst)
        (!lock_done && bus_we && bus_addr == '0) |=> (lock_level == $past(bus_wdata[9:8])));

    assert_lock_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        lock_done |=> $stable(lock_level));

    assert_open_write_R3: assert property (@(posedge clk) disable iff (rst)
        (lock_level == 2'd0 && bus_we && bus_addr == AW'(1)) |=> (idle_lvl == $past(bus_wdata[2*NCH-1:0])));

    assert_basic_freeze_R4: assert property (@(posedge clk) disable iff (rst)
        (lock_level != 2'd0) |=> ($stable(main_cfg[7:0]) && $stable(main_cfg[31:12]) && $stable(idle_lvl)));

    assert_offsel_freeze_R5: assert property (@(posedge clk) disable iff (rst)
        (lock_level >= 2'd2) |=> $stable(main_cfg[11:10]));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        assert_pol_freeze_R5: assert property (@(posedge clk) disable iff (rst)
            (lock_level >= 2'd2 && ch_is_out[c]) |=> $stable(out_pol[2*c +: 2]));

        assert_mode_freeze_R6: assert property (@(posedge clk) disable iff (rst)
            (lock_level == 2'd3 && ch_is_out[c]) |=> $stable(out_mode[SLOT_W*c +: SLOT_W]));

        assert_input_chan_open_R7: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == AW'(2) && !ch_is_out[c]) |=> (out_pol[2*c +: 2] == $past(bus_wdata[2*c +: 2])));
    end

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (main_cfg == '0 && idle_lvl == '0 && out_pol == '0 && out_mode == '0 && !lock_done));
endmodule

bind prot_lock_regs prot_lock_chk #(.NCH(NCH), .MODE_W(MODE_W), .AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .ch_is_out  (ch_is_out),
    .main_cfg   (main_cfg),
    .idle_lvl   (idle_lvl),
    .out_pol    (out_pol),
    .out_mode   (out_mode),
    .lock_level (lock_level),
    .lock_done  (lock_done)
);

// File: tb/tb_prot_lock_regs.sv
`timescale 1ns/1ps
module tb_prot_lock_regs;
    localparam int NCH = 4;
    localparam int MODE_W = 3;
    localparam int AW = 2;
    localparam int SW = MODE_W + 1;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 bus_we = 1'b0;
    logic [AW-1:0]        bus_addr = '0;
    logic [31:0]          bus_wdata = '0;
    logic [NCH-1:0]       ch_is_out = '0;
    logic [31:0]          main_cfg;
    logic [2*NCH-1:0]     idle_lvl;
    logic [2*NCH-1:0]     out_pol;
    logic [NCH*SW-1:0]    out_mode;
    logic [1:0]           lock_level;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0]       m_main;
    logic [1:0]        m_lock;
    bit                m_done;
    logic [2*NCH-1:0]  m_idle, m_pol;
    logic [NCH*SW-1:0] m_mode;

    always #5 clk = ~clk;

    prot_lock_regs #(.NCH(NCH), .MODE_W(MODE_W), .AW(AW)) dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .ch_is_out(ch_is_out), .main_cfg(main_cfg),
        .idle_lvl(idle_lvl), .out_pol(out_pol), .out_mode(out_mode),
        .lock_level(lock_level)
    );

    function automatic logic [31:0] main_mask(input logic [1:0] l);
        if (l == 2'd0) return 32'hFF3F_7CFF;
        if (l == 2'd1) return 32'h0000_0C00;
        return 32'h0;
    endfunction

    function automatic logic [31:0] exp_main();
        logic [31:0] v = m_main;
        v[9:8] = m_lock;
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " main"}, main_cfg, exp_main());
        check({tag, " lock"}, 32'(lock_level), 32'(m_lock));
        check({tag, " idle"}, 32'(idle_lvl), 32'(m_idle));
        check({tag, " pol"},  32'(out_pol),  32'(m_pol));
        check({tag, " mode"}, 32'(out_mode), 32'(m_mode));
    endtask

    task automatic model_clear();
        m_main = '0; m_lock = '0; m_done = 0;
        m_idle = '0; m_pol = '0; m_mode = '0;
    endtask

    task automatic model_write(input logic [1:0] a, input logic [31:0] d, input logic [NCH-1:0] outs);
        logic [31:0] mk;
        case (a)
            2'd0: begin
                mk = main_mask(m_lock);
                m_main = (m_main & ~mk) | (d & mk);
                if (!m_done) begin m_lock = d[9:8]; m_done = 1; end
            end
            2'd1: if (m_lock == 2'd0) m_idle = d[2*NCH-1:0];
            2'd2: for (int c = 0; c < NCH; c++)
                      if (!(m_lock >= 2'd2 && outs[c])) m_pol[2*c +: 2] = d[2*c +: 2];
            default: for (int c = 0; c < NCH; c++)
                      if (!(m_lock == 2'd3 && outs[c])) m_mode[SW*c +: SW] = d[SW*c +: SW];
        endcase
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_clear();
        check_all(tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [NCH-1:0] outs, input string tag);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; ch_is_out = outs;
        @(negedge clk);
        bus_we = 1'b0;
        model_write(a, d, outs);
        check_all(tag);
    endtask

    initial begin
        #(10ns * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        check_all("R9 reset state");

        // R1: a write to another address leaves the lock uncommitted; lock 0 commits
        wr(2'd1, 32'h0000_00A5, '0, "R3 idle open");
        wr(2'd0, 32'h0000_0012, '0, "R1 commit zero");
        wr(2'd0, 32'hFFFF_FFFF, '0, "R2 later lock ignored");
        check("R2 lock still zero", 32'(lock_level), 32'd0);
        check("R3 reserved bits zero", 32'(main_cfg & 32'h00C0_8000), 32'd0);

        // R4 and R8: level 1, mixed write
        do_reset("R9 reset after level0");
        wr(2'd0, 32'hA5A5_A5A5 & ~32'h0000_0300 | 32'h0000_0100, '0, "R1 commit level1");
        wr(2'd0, 32'h5A5A_5A5A, '0, "R8 level1 mixed");
        wr(2'd1, 32'h0000_00FF, '0, "R4 idle frozen");

        // R5 and R7: level 2 with mixed channel roles
        do_reset("R9 reset after level1");
        wr(2'd2, 32'h0000_00FF, '0, "R3 pol open");
        wr(2'd0, 32'h0000_0E00, '0, "R1 commit level2");
        wr(2'd0, 32'h0000_0000, '0, "R5 offsel frozen");
        wr(2'd2, 32'h0000_0000, 4'b0101, "R5 pol output frozen R7 input open");
        wr(2'd3, 32'h0000_FFFF, 4'b1111, "R5 mode open at level2");

        // R6 and R7: level 3
        do_reset("R9 reset after level2");
        wr(2'd0, 32'h0000_0300, '0, "R1 commit level3");
        wr(2'd3, 32'h0000_ABCD, 4'b0011, "R6 mode output frozen R7 input open");
        wr(2'd3, 32'h0000_1234, 4'b0000, "R7 all inputs open");
        wr(2'd2, 32'h0000_00C3, 4'b1000, "R5 pol at level3");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] a;
            logic [31:0] d;
            logic [NCH-1:0] o;
            if (($urandom % 150) == 0) do_reset("R9 random reset");
            a = 2'($urandom % 4);
            d = $urandom;
            o = NCH'($urandom);
            wr(a, d, o, "R8 random");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule